// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Table

This block is a small route table searched by ternary compare. Each of its rows holds a stored address, a care mask, a valid flag and a result code. The result code might be a next-hop number or an egress port number. Software fills a row through the write port by giving a row number, an address, a prefix length and a result. The block builds the care mask from the prefix length: the leading prefix bits must match, and the trailing host bits are don't-care. Software must keep rows ordered from the longest prefix at row 0 to the shortest at the last row.

A lookup presents a destination key. In one cycle the key is compared against every valid row. The lowest-numbered matching row wins, and because of the ordering rule that row holds the longest matching prefix. The winner's row number and result, with a hit flag, are registered and appear one cycle later. When no row matches, the hit flag is low and the result is a configurable default route code.

A two-state response machine tracks the lookup pipeline. The state LK_IDLE means no response is pending, and LK_DONE means a response is on the outputs this cycle. The transition take_req (a lookup request is sampled) goes from either state to LK_DONE. The transition no_req (no request is sampled) goes from either state to LK_IDLE.

Top module: `lpm_tcam`

## Requirements
- R1: After reset every row is invalid, and rsp_valid and rsp_hit are 0. A lookup issued before any write misses.
- R2: rsp_valid is 1 in exactly the cycle after a cycle in which lk_req was sampled high, and 0 otherwise.
- R3: A valid row written with prefix length L matches a key when the top L bits of the key (bit 31 downward) equal the top L bits of the stored address. The lower 32-L bits are ignored.
- R4: When several valid rows match, rsp_index is the lowest matching row number, rsp_result is that row's result, and rsp_hit is 1.
- R5: When no valid row matches, rsp_hit is 0, rsp_index is 0 and rsp_result equals the parameter DEFAULT_RESULT (8'hFF by default).
- R6: A prefix length of 0 makes the row match every key. A length above 32 is treated as 32, which means an exact match on all bits.
- R7: An invalidate (wr_en=1, wr_del=1) clears only the valid flag of row wr_row. All other rows keep matching as before.
- R8: A write in the same cycle as a lookup is not seen by that lookup, but it is seen by lookups issued on later cycles.
- R9: Writing a row that already holds an entry replaces its address, length and result, and leaves the row valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Row write or invalidate strobe |
| wr_del | input | 1 | With wr_en: 1 invalidates the row, 0 loads it |
| wr_row | input | 5 | Row number to write |
| wr_value | input | 32 | Route address to store |
| wr_len | input | 6 | Prefix length, 0 to 32 (larger values clamp to 32) |
| wr_result | input | 8 | Result code stored in the row |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 32 | Destination key to search |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | At least one row matched |
| rsp_index | output | 5 | Winning row number (0 on miss) |
| rsp_result | output | 8 | Winning row result, or the default route code on a miss |

## Verification
The bench sets up overlapping prefixes in which a shorter route sits below a longer one. A reversed or missing priority encoder would then return the wrong row. Keys that differ from a stored address only below the prefix length show whether the mask is wrong: a mask built in the wrong direction or off by one either misses such a key or matches a key one bit outside the prefix. Zero-length rows, lengths above 32, an invalidate between two adjacent matching rows, and a write that lands in the same cycle as a lookup of that row each target a distinct mistake. Those mistakes are a match-all row that never matches, a shift that wraps, an invalidate that clears neighbouring rows, and a write that bypasses into the lookup already in flight. Random keys derived from stored addresses are checked against a reference model kept in the bench.

// File: rtl/lpm_tcam_pkg.sv
package lpm_tcam_pkg;
    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_DONE = 1'b1
    } lk_state_t;
endpackage

// File: rtl/lpm_tcam_rows.sv
module lpm_tcam_rows #(
    parameter int KEY_W = 32,
    parameter int ROWS  = 32,
    parameter int RES_W = 8,
    localparam int IDX_W = $clog2(ROWS),
    localparam int LEN_W = $clog2(KEY_W + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_del,
    input  logic [IDX_W-1:0]             wr_row,
    input  logic [KEY_W-1:0]             wr_value,
    input  logic [LEN_W-1:0]             wr_len,
    input  logic [RES_W-1:0]             wr_result,
    output logic [ROWS-1:0]              row_valid,
    output logic [ROWS-1:0][KEY_W-1:0]   row_value,
    output logic [ROWS-1:0][KEY_W-1:0]   row_mask,
    output logic [ROWS-1:0][RES_W-1:0]   row_result
);
    logic [KEY_W-1:0] new_mask;

    // Care bits are the leading prefix bits, counted from the MSB.
    always_comb begin
        int eff;
        eff = (int'(wr_len) > KEY_W) ? KEY_W : int'(wr_len);
        for (int i = 0; i < KEY_W; i++) begin
            new_mask[i] = (i >= KEY_W - eff);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= '0;
        end else if (wr_en && (int'(wr_row) < ROWS)) begin
            if (wr_del) begin
                row_valid[wr_row] <= 1'b0;
            end else begin
                row_valid[wr_row]  <= 1'b1;
                row_value[wr_row]  <= wr_value;
                row_mask[wr_row]   <= new_mask;
                row_result[wr_row] <= wr_result;
            end
        end
    end

    // R7: an invalidate leaves the addressed row invalid
    p_invalidate_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_del && int'(wr_row) < ROWS) |=> !row_valid[$past(wr_row)]);

    // R9: a load leaves the addressed row valid
    p_load_sets_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_del && int'(wr_row) < ROWS) |=> row_valid[$past(wr_row)]);
endmodule

// File: rtl/lpm_tcam_match.sv
module lpm_tcam_match #(
    parameter int KEY_W = 32,
    parameter int ROWS  = 32
) (
    input  logic [KEY_W-1:0]             key,
    input  logic [ROWS-1:0]              row_valid,
    input  logic [ROWS-1:0][KEY_W-1:0]   row_value,
    input  logic [ROWS-1:0][KEY_W-1:0]   row_mask,
    output logic [ROWS-1:0]              match_vec
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign match_vec[r] = row_valid[r] &&
                              (((key ^ row_value[r]) & row_mask[r]) == '0);
    end
endmodule

// File: rtl/lpm_tcam_pick.sv
module lpm_tcam_pick #(
    parameter int ROWS = 32,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0]  match_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        win_idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

    assign any_hit = |match_vec;

    // R4: no matching row sits below the chosen one
    always_comb begin
        if (any_hit) begin
            a_lowest_wins_r4: assert (match_vec[win_idx] &&
                ((match_vec & ((ROWS'(1) << win_idx) - ROWS'(1))) == '0));
        end
    end
endmodule

// File: rtl/lpm_tcam.sv
module lpm_tcam
    import lpm_tcam_pkg::*;
#(
    parameter int KEY_W = 32,
    parameter int ROWS  = 32,
    parameter int RES_W = 8,
    parameter logic [RES_W-1:0] DEFAULT_RESULT = 8'hFF,
    localparam int IDX_W = $clog2(ROWS),
    localparam int LEN_W = $clog2(KEY_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_del,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [RES_W-1:0] wr_result,
    input  logic             lk_req,
    input  logic [KEY_W-1:0] lk_key,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_index,
    output logic [RES_W-1:0] rsp_result
);
    logic [ROWS-1:0]             row_valid;
    logic [ROWS-1:0][KEY_W-1:0]  row_value;
    logic [ROWS-1:0][KEY_W-1:0]  row_mask;
    logic [ROWS-1:0][RES_W-1:0]  row_result;
    logic [ROWS-1:0]             match_vec;
    logic                        any_hit;
    logic [IDX_W-1:0]            win_idx;
    lk_state_t                   state;

    lpm_tcam_rows #(.KEY_W(KEY_W), .ROWS(ROWS), .RES_W(RES_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_del(wr_del),
        .wr_row(wr_row), .wr_value(wr_value), .wr_len(wr_len),
        .wr_result(wr_result), .row_valid(row_valid), .row_value(row_value),
        .row_mask(row_mask), .row_result(row_result)
    );

    lpm_tcam_match #(.KEY_W(KEY_W), .ROWS(ROWS)) u_match (
        .key(lk_key), .row_valid(row_valid), .row_value(row_value),
        .row_mask(row_mask), .match_vec(match_vec)
    );

    lpm_tcam_pick #(.ROWS(ROWS)) u_pick (
        .match_vec(match_vec), .any_hit(any_hit), .win_idx(win_idx)
    );

    // State register: take_req -> LK_DONE, no_req -> LK_IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_IDLE;
        end else begin
            state <= lk_req ? LK_DONE : LK_IDLE;
        end
    end

    // Response capture; rows are read before this edge's write lands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit    <= 1'b0;
            rsp_index  <= '0;
            rsp_result <= DEFAULT_RESULT;
        end else if (lk_req) begin
            rsp_hit    <= any_hit;
            rsp_index  <= any_hit ? win_idx : '0;
            rsp_result <= any_hit ? row_result[win_idx] : DEFAULT_RESULT;
        end
    end

    always_comb begin
        unique case (state)
            LK_IDLE: rsp_valid = 1'b0;
            LK_DONE: rsp_valid = 1'b1;
            default: rsp_valid = 1'b0;
        endcase
    end

    // R2: a response follows each request and only a request
    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    p_no_resp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R5: a miss reports the default route and row zero
    p_miss_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_result == DEFAULT_RESULT && rsp_index == '0));

    // R4: a hit needs a matching row at request time
    p_hit_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && match_vec == '0) |=> !rsp_hit);
endmodule

// File: tb/lpm_tcam_test.sv
module lpm_tcam_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_del = 1'b0;
    logic [4:0]  wr_row = '0;
    logic [31:0] wr_value = '0;
    logic [5:0]  wr_len = '0;
    logic [7:0]  wr_result = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_key = '0;
    logic        rsp_valid, rsp_hit;
    logic [4:0]  rsp_index;
    logic [7:0]  rsp_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_val [32];
    int          m_len [32];
    logic [7:0]  m_res [32];
    bit          m_vld [32];
    bit          e_hit;
    logic [4:0]  e_idx;
    logic [7:0]  e_res;

    lpm_tcam uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_del(wr_del),
        .wr_row(wr_row), .wr_value(wr_value), .wr_len(wr_len),
        .wr_result(wr_result), .lk_req(lk_req), .lk_key(lk_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
        .rsp_result(rsp_result)
    );

    always #4 clk = ~clk;

    function automatic bit row_hits(logic [31:0] key, int r);
        int l;
        l = (m_len[r] > 32) ? 32 : m_len[r];
        if (!m_vld[r]) return 1'b0;
        for (int b = 31; b >= 32 - l; b--) begin
            if (key[b] != m_val[r][b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic expect_for(input logic [31:0] key);
        e_hit = 1'b0; e_idx = '0; e_res = 8'hFF;
        for (int r = 0; r < 32; r++) begin
            if (!e_hit && row_hits(key, r)) begin
                e_hit = 1'b1; e_idx = 5'(r); e_res = m_res[r];
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_row(input int r, input logic [31:0] v, input int l, input logic [7:0] res);
        wr_en = 1'b1; wr_del = 1'b0; wr_row = 5'(r); wr_value = v;
        wr_len = 6'(l); wr_result = res;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        m_vld[r] = 1'b1; m_val[r] = v; m_len[r] = l; m_res[r] = res;
    endtask

    task automatic kill_row(input int r);
        wr_en = 1'b1; wr_del = 1'b1; wr_row = 5'(r);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_del = 1'b0;
        m_vld[r] = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic [31:0] key);
        expect_for(key);
        lk_req = 1'b1; lk_key = key;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
        check({tag, " index"}, 32'(rsp_index), 32'(e_idx));
        check({tag, " result"}, 32'(rsp_result), 32'(e_res));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] k;
        int r, l;
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 32; i++) begin
            m_vld[i] = 1'b0; m_val[i] = '0; m_len[i] = 0; m_res[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        check("R1 reset hit", 32'(rsp_hit), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        lookup("R1 empty", 32'h0A000001);
        @(negedge clk);
        check("R2 idle no valid", 32'(rsp_valid), 32'd0);

        // Ordered prefixes: /24, /16, /8, default
        write_row(0, 32'h0A0B0C00, 24, 8'h11);
        write_row(1, 32'h0A0B0000, 16, 8'h22);
        write_row(2, 32'h0A000000, 8,  8'h33);
        lookup("R3 R4 longest /24", 32'h0A0B0C7F);
        lookup("R3 R4 falls to /16", 32'h0A0B0D01);
        lookup("R3 falls to /8", 32'h0AFF0000);
        lookup("R5 miss", 32'h0B000000);
        lookup("R3 bit outside prefix", 32'h0A0B0E00);
        write_row(31, 32'hDEADBEEF, 0, 8'h77);
        lookup("R6 zero length matches all", 32'h0B000000);
        write_row(5, 32'hC0A80101, 40, 8'h55);
        lookup("R6 clamp exact", 32'hC0A80101);
        lookup("R6 clamp one bit off", 32'hC0A80100);

        // R7: drop row 1 only
        kill_row(1);
        lookup("R7 row1 gone", 32'h0A0B0D01);
        lookup("R7 row0 kept", 32'h0A0B0C01);

        // R9: overwrite row 0
        write_row(0, 32'h0A0B0C80, 25, 8'h99);
        lookup("R9 overwrite hit", 32'h0A0B0C81);
        lookup("R9 old half now lower", 32'h0A0B0C01);

        // R8: write row 3 while looking up its key
        expect_for(32'h0B0B0B0B);
        lk_req = 1'b1; lk_key = 32'h0B0B0B0B;
        wr_en = 1'b1; wr_del = 1'b0; wr_row = 5'd3; wr_value = 32'h0B0B0B0B;
        wr_len = 6'd32; wr_result = 8'h44;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b0;
        m_vld[3] = 1'b1; m_val[3] = 32'h0B0B0B0B; m_len[3] = 32; m_res[3] = 8'h44;
        check("R8 same cycle old index", 32'(rsp_index), 32'(e_idx));
        check("R8 same cycle old result", 32'(rsp_result), 32'(e_res));
        lookup("R8 later sees write", 32'h0B0B0B0B);

        // Random fill and lookups
        for (int i = 0; i < 24; i++) begin
            r = int'($urandom_range(30, 0));
            l = int'($urandom_range(33, 0));
            if ($urandom_range(7, 0) == 0) kill_row(r);
            else write_row(r, $urandom(), l, 8'($urandom()));
        end
        for (int i = 0; i < 150; i++) begin
            r = int'($urandom_range(31, 0));
            k = m_val[r] ^ ($urandom() >> $urandom_range(31, 0));
            lookup("R4 random", k);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule